// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Aggregator

This block gathers 32 interrupt sources into one request line for a processor. Each source has a fixed trigger class. An edge-class source sets a latch bit on a rising transition, and that bit holds until software clears it. A level-class source shows its sampled input directly. A software request word can also add bits to the status word. The status word is ANDed with an enable word, and any surviving bit raises the request.

The block also presents the lowest-numbered pending enabled source as an index with a valid flag, so a dispatcher can branch without scanning. Software reaches the four registers through a plain synchronous port. The port has a 2-bit address, a write strobe, write data and registered read data.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the enable, latch and software-request registers read as zero, `irq_o` and `pend_valid_o` are low, and `pend_idx_o` is 0.
- R2: A level-class source (every bit outside 16-19, 22-24 and 28-30) is sampled on each clock. Its status bit equals the input seen at the previous clock edge, and it clears when the input falls.
- R3: An edge-class source (bits 16-19, 22-24, 28-30) sets its latch bit when its input is high at a clock edge after being low at the edge before. The bit stays set after the input falls.
- R4: A write to address 2 replaces the edge-class bits of the latch register with the written data. Writing 0 clears a latched bit and writing 1 sets it. Without such a write, a latched bit never clears.
- R5: If a rising edge and a write of 0 to the same latch bit happen in the same cycle, the bit ends up set.
- R6: The status word is the sampled level bits OR the latch register OR the software-request register. The software-request register is read and written at address 3.
- R7: `irq_o` is high exactly when status AND enable is nonzero. A status bit whose enable bit (address 1) is clear does not raise it.
- R8: `pend_valid_o` equals `irq_o`. `pend_idx_o` is the lowest set bit position of status AND enable, or 0 when that word is zero.
- R9: `rdata_o` is registered. One cycle after `addr_i` selects status (0), enable (1), latch (2) or software request (3), it shows the value that register held before that clock edge.
- R10: Writes to address 0 change nothing. Level-class positions of the latch register always read 0, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Raw interrupt source inputs |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| pend_idx_o | output | 5 | Lowest pending enabled source |
| pend_valid_o | output | 1 | Pending index is meaningful |

## Verification
The assertions assume that `src_i`, `addr_i`, `we_i` and `wdata_i` change only between clock edges and hold a single value at each edge. They also assume that reset is held for at least one edge before the first check. The bench meets both conditions by driving every input on the falling edge and holding reset low for several cycles. The bench also raises a source and issues a clear in the same cycle, on purpose, to exercise the edge-wins rule. Apart from that case, writes and source changes need no ordering between them.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned SRC_N_DEF = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam logic [31:0] EDGE_CLASS_DEF = 32'h71CF_0000;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_ENABLE = 2'd1,
    RA_LATCH  = 2'd2,
    RA_SWREQ  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_CLASS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         latch_we_i,
  input  logic [N-1:0] latch_wdata_i,
  output logic [N-1:0] samp_o,
  output logic [N-1:0] latch_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] samp_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] base_w;
  logic [N-1:0] latch_d;

  assign rise_o  = src_i & ~samp_q & EDGE_CLASS;
  assign base_w  = latch_we_i ? latch_wdata_i : latch_q;
  assign latch_d = (base_w | rise_o) & EDGE_CLASS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q  <= '0;
      latch_q <= '0;
    end else begin
      samp_q  <= src_i;
      latch_q <= latch_d;
    end
  end

  assign samp_o  = samp_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      latch_i,
  output logic [N-1:0]      enable_o,
  output logic [N-1:0]      swreq_o,
  output logic [N-1:0]      rdata_o
);
  reg_addr_e    sel;
  logic [N-1:0] enable_q;
  logic [N-1:0] swreq_q;
  logic [N-1:0] rdata_q;
  logic [N-1:0] rd_mux;

  assign sel = reg_addr_e'(addr_i);

  always_comb begin
    case (sel)
      RA_STATUS: rd_mux = status_i;
      RA_ENABLE: rd_mux = enable_q;
      RA_LATCH:  rd_mux = latch_i;
      default:   rd_mux = swreq_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      swreq_q  <= '0;
      rdata_q  <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (we_i && sel == RA_ENABLE) enable_q <= wdata_i;
      if (we_i && sel == RA_SWREQ)  swreq_q  <= wdata_i;
    end
  end

  assign enable_o = enable_q;
  assign swreq_o  = swreq_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | vec_i[g];
    assign first[g]  = vec_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = seen[N];
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N_DEF,
  parameter logic [N_SRC-1:0] EDGE_CLASS = EDGE_CLASS_DEF[N_SRC-1:0],
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              pend_valid_o
);
  logic [N_SRC-1:0] samp_w;
  logic [N_SRC-1:0] latch_w;
  logic [N_SRC-1:0] rise_w;
  logic [N_SRC-1:0] enable_w;
  logic [N_SRC-1:0] swreq_w;
  logic [N_SRC-1:0] status_w;
  logic [N_SRC-1:0] masked_w;
  logic             latch_wr_w;

  assign latch_wr_w = we_i && (reg_addr_e'(addr_i) == RA_LATCH);

  irqagg_capture #(.N(N_SRC), .EDGE_CLASS(EDGE_CLASS)) u_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_i         (src_i),
    .latch_we_i    (latch_wr_w),
    .latch_wdata_i (wdata_i),
    .samp_o        (samp_w),
    .latch_o       (latch_w),
    .rise_o        (rise_w)
  );

  assign status_w = (samp_w & ~EDGE_CLASS) | latch_w | swreq_w;
  assign masked_w = status_w & enable_w;
  assign irq_o    = |masked_w;

  irqagg_regs #(.N(N_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .status_i (status_w),
    .latch_i  (latch_w),
    .enable_o (enable_w),
    .swreq_o  (swreq_w),
    .rdata_o  (rdata_o)
  );

  irqagg_prio #(.N(N_SRC), .IW(IDX_W)) u_prio (
    .vec_i (masked_w),
    .idx_o (pend_idx_o),
    .any_o (pend_valid_o)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_wr,
  input logic          irq_o,
  input logic          pend_valid_o,
  input logic [IW-1:0] pend_idx_o,
  input logic [N-1:0]  status_w,
  input logic [N-1:0]  enable_w,
  input logic [N-1:0]  latch_w,
  input logic [N-1:0]  rise_w
);
  logic [N-1:0] one_w;
  logic [N-1:0] below_w;
  assign one_w   = {{(N-1){1'b0}}, 1'b1};
  assign below_w = (one_w << pend_idx_o) - one_w;

  assert_reset_clear_R1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (enable_w == '0 && latch_w == '0 && !irq_o));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr |=> ((latch_w & $past(latch_w)) == $past(latch_w)));

  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((latch_w & $past(rise_w)) == $past(rise_w)));

  assert_valid_tracks_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == irq_o);

  assert_idx_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (status_w[pend_idx_o] && enable_w[pend_idx_o]));

  assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> ((status_w & enable_w & below_w) == '0));
endmodule

bind irqagg_top irqagg_checker #(.N(N_SRC), .IW(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .latch_wr     (latch_wr_w),
  .irq_o        (irq_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o),
  .status_w     (status_w),
  .enable_w     (enable_w),
  .latch_w      (latch_w),
  .rise_w       (rise_w)
);

// File: tb/irqagg_top_test.sv
`timescale 1ns/1ps
module irqagg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [4:0]  pidx;
  logic        pvalid;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  irqagg_top uut (
    .clk (clk), .rst_n (rst_n), .src_i (src), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq), .pend_idx_o (pidx),
    .pend_valid_o (pvalid)
  );

  function automatic bit is_edge(int i);
    return (i >= 16 && i <= 19) || (i >= 22 && i <= 24) || (i >= 28 && i <= 30);
  endfunction

  // behavioural reference model
  logic [31:0] m_samp, m_latch, m_en, m_sw, m_rd, m_st, m_nl;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_samp = '0; m_latch = '0; m_en = '0; m_sw = '0; m_rd = '0;
    end else begin
      for (int i = 0; i < 32; i++)
        m_st[i] = (m_samp[i] && !is_edge(i)) || m_latch[i] || m_sw[i];
      case (addr)
        2'd0: m_rd = m_st;
        2'd1: m_rd = m_en;
        2'd2: m_rd = m_latch;
        default: m_rd = m_sw;
      endcase
      m_nl = m_latch;
      for (int i = 0; i < 32; i++) begin
        if (we && addr == 2'd2) m_nl[i] = wdata[i] && is_edge(i);
        if (is_edge(i) && src[i] && !m_samp[i]) m_nl[i] = 1'b1;
      end
      if (we && addr == 2'd1) m_en = wdata;
      if (we && addr == 2'd3) m_sw = wdata;
      m_latch = m_nl;
      m_samp = src;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] st, mk;
      int exp_idx;
      bit hit;
      exp_idx = 0;
      hit = 1'b0;
      for (int i = 0; i < 32; i++)
        st[i] = (m_samp[i] && !is_edge(i)) || m_latch[i] || m_sw[i];
      mk = st & m_en;
      for (int i = 0; i < 32; i++) if (mk[i] && !hit) begin exp_idx = i; hit = 1'b1; end
      n_chk++;
      if (irq !== (mk != 0) || pvalid !== (mk != 0) || pidx !== 5'(exp_idx) || rdata !== m_rd) begin
        n_fail++;
        $display("FAIL %s(R7/R8/R9 ref) actual irq=%b v=%b idx=%0d rd=%h expected irq=%b idx=%0d rd=%h",
                 phase, irq, pvalid, pidx, rdata, mk != 0, exp_idx, m_rd);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); v = rdata;
  endtask
  task automatic drive(logic [31:0] v);
    @(negedge clk); src = v;
  endtask

  initial begin
    logic [31:0] v;
    tick(4);
    rst_n = 1'b1;
    // R1 reset state
    phase = "R1";
    rd(2'd1, v); chk("R1 enable", v, 0);
    rd(2'd2, v); chk("R1 latch", v, 0);
    rd(2'd3, v); chk("R1 swreq", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R2 level sources
    phase = "R2";
    wr(2'd1, 32'hFFFF_FFFF);
    drive(32'h0000_0005); tick();
    chk("R2 irq", {31'd0, irq}, 1);
    chk("R2 idx0", {27'd0, pidx}, 0);
    drive(32'h0000_0004); tick();
    chk("R2 idx2", {27'd0, pidx}, 2);
    drive(32'h0); tick();
    chk("R2 fall", {31'd0, irq}, 0);
    // R3 edge latch
    phase = "R3";
    drive(32'h0002_0000); drive(32'h0); tick(2);
    rd(2'd2, v); chk("R3 latch", v, 32'h0002_0000);
    chk("R3 idx17", {27'd0, pidx}, 17);
    rd(2'd0, v); chk("R9 status read", v, 32'h0002_0000);
    // R4 software clear and set
    phase = "R4";
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R4 cleared", v, 0);
    chk("R4 irq", {31'd0, irq}, 0);
    wr(2'd2, 32'h0001_0000);
    rd(2'd2, v); chk("R4 set", v, 32'h0001_0000);
    wr(2'd2, 32'h0);
    // R5 edge wins over clear
    phase = "R5";
    drive(32'h0004_0000); drive(32'h0); tick();
    @(negedge clk); src = 32'h0004_0000; addr = 2'd2; wdata = 32'h0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(2'd2, v); chk("R5 edge wins", v, 32'h0004_0000);
    drive(32'h0); wr(2'd2, 32'h0);
    // R6 software request
    phase = "R6";
    wr(2'd3, 32'h8000_0000);
    chk("R6 idx31", {27'd0, pidx}, 31);
    rd(2'd0, v); chk("R6 status", v, 32'h8000_0000);
    rd(2'd3, v); chk("R6 swreq", v, 32'h8000_0000);
    // R7 spurious when disabled
    phase = "R7";
    wr(2'd1, 32'h7FFF_FFFF);
    chk("R7 masked", {31'd0, irq}, 0);
    rd(2'd0, v); chk("R7 raw kept", v, 32'h8000_0000);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'h0);
    // R8 lowest enabled wins
    phase = "R8";
    drive(32'h0200_0020); tick();
    chk("R8 idx5", {27'd0, pidx}, 5);
    wr(2'd1, ~32'h20);
    chk("R8 idx25", {27'd0, pidx}, 25);
    chk("R8 valid", {31'd0, pvalid}, 1);
    drive(32'h0); tick();
    chk("R8 none idx", {27'd0, pidx}, 0);
    // R10 ignored writes
    phase = "R10";
    wr(2'd1, 32'h1234_5678);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R10 enable kept", v, 32'h1234_5678);
    rd(2'd3, v); chk("R10 swreq kept", v, 0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R10 level bits zero", v, 32'h71CF_0000);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R10 cleared", v, 0);
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule